// File: doc/BRIEF.md
# Audio sample FIFO controller with level interrupts

This block sits between a processor-side register port and an audio serialiser. It buffers 32-bit audio words in a transmit queue, which software fills and the serialiser drains, and in a receive queue, which the serialiser fills and software drains. Software reads the fill levels in a status word. It can empty either queue with a flush bit that it sets and then clears again. Two counters track how many words have moved through each direction.

Three event flags are held in an interrupt status register: transmit space available, transmit underrun and receive data available. Each flag is sticky and is cleared by writing one to it. A flag whose condition still holds sets again at once. An interrupt enable register has the same bit layout, and the interrupt line is high whenever a set flag is also enabled. The transmit-space flag compares the free entry count against a programmable trigger level. Serialisation and clock generation are outside this block.

Register offsets (byte addresses): control 0x00, FIFO control 0x04, level 0x08, interrupt status 0x0C, interrupt enable 0x10, transmit data 0x14, receive data 0x18, transmit counter 0x1C, receive counter 0x20. Unmapped offsets read as zero. Register accesses take effect on the clock edge. Read data is combinational from the offset.

Top module: `audio_fifo_ctrl`

## Requirements
- R1: After reset both queues are empty and the level register reads 0x0080_0000. FIFO control reads 0x0004_0000 (trigger 64). Control, interrupt enable and both counters read 0, and the interrupt line is low.
- R2: A write to transmit data appends a word. While control bit 2 (transmit enable) is 1, each serialiser request is answered in the same cycle by tx_ack_o and the oldest word on tx_word_o. Level bits 23:16 hold the transmit free count (128 minus the number of stored words).
- R3: While control bit 1 (receive enable) is 1, a word offered with rx_valid_i is stored. Reads of receive data return the stored words oldest first and remove them. Level bits 5:0 hold the receive available count. Reading an empty queue returns 0.
- R4: While FIFO control bit 25 is 1 the transmit queue is held empty, and while bit 24 is 1 the receive queue is held empty. Words offered during that time are discarded.
- R5: Interrupt status bit 4 sets whenever the transmit free count is greater than or equal to FIFO control bits 18:12 (the trigger level).
- R6: Interrupt status bit 6 sets when the serialiser requests a word while transmit is enabled and no word is delivered. tx_ack_o is low in that cycle.
- R7: Interrupt status bit 0 sets whenever the receive available count is nonzero.
- R8: Writing interrupt status clears each bit written as 1, unless its condition holds in that cycle. Bits written as 0 keep their value.
- R9: irq_o is high exactly when some interrupt status bit and the enable bit at the same position (bits 6, 4, 0 of the enable register) are both 1.
- R10: The transmit counter adds one per delivered word and the receive counter adds one per stored word. A write loads the written value, so writing 0 restarts it.
- R11: With transmit enable 0, requests are ignored: no word leaves, no underrun, no count. With receive enable 0, offered words are ignored. Each direction is independent of the other.
- R12: A word offered to a full queue is dropped. The stored contents, the level and (for receive) the counter are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rd_i | input | 1 | Register read strobe (pops receive data) |
| reg_rdata_o | output | 32 | Register read data |
| tx_req_i | input | 1 | Serialiser requests a transmit word |
| tx_ack_o | output | 1 | Word delivered this cycle |
| tx_word_o | output | 32 | Delivered transmit word |
| rx_valid_i | input | 1 | Serialiser offers a received word |
| rx_word_i | input | 32 | Received word |
| irq_o | output | 1 | Interrupt request |

## Verification
The space flag is driven by a table that pairs trigger levels with fill amounts. The table covers free counts just above, at and just below each trigger, plus trigger 0, trigger 127 and an overfilled queue. This separates a greater-or-equal comparison from a strict one and from an off-by-one free count. Directed sequences move distinct word values through both queues to expose ordering errors. They request from an empty queue and toggle each enable alone to show that the two directions do not interact. Further writes test clear-by-one against write-zero, and the enable masks, on sticky flags whose conditions have lapsed.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int REG_W = 32;
  localparam int STS_W = 7;

  // register byte offsets
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_FCTL   = 8'h04;
  localparam logic [7:0] OFS_LEVEL  = 8'h08;
  localparam logic [7:0] OFS_ISTS   = 8'h0C;
  localparam logic [7:0] OFS_IEN    = 8'h10;
  localparam logic [7:0] OFS_TXDATA = 8'h14;
  localparam logic [7:0] OFS_RXDATA = 8'h18;
  localparam logic [7:0] OFS_TXCNT  = 8'h1C;
  localparam logic [7:0] OFS_RXCNT  = 8'h20;

  // field positions
  localparam int CTRL_TXEN    = 2;
  localparam int CTRL_RXEN    = 1;
  localparam int FCTL_TXFLUSH = 25;
  localparam int FCTL_RXFLUSH = 24;
  localparam int TRIG_LSB     = 12;
  localparam int TRIG_W       = 7;
  localparam int FREE_LSB     = 16;
  localparam int FREE_W       = 8;
  localparam int AVAIL_W      = 6;

  localparam int ISTS_UNDERRUN = 6;
  localparam int ISTS_TXSPACE  = 4;
  localparam int ISTS_RXAVAIL  = 0;
  localparam logic [STS_W-1:0] ISTS_IMPL = 7'b101_0001;
endpackage

// File: rtl/afc_rst_sync.sv
module afc_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/afc_fifo.sv
// Circular word queue; DEPTH must be a power of two.
module afc_fifo #(
  parameter  int DEPTH = 128,
  parameter  int DW    = 32,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          push_ok_o,
  output logic          pop_ok_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign full_o    = (cnt_q == CW'(DEPTH));
  assign empty_o   = (cnt_q == '0);
  assign push_ok_o = push_i && !full_o && !flush_i;
  assign pop_ok_o  = pop_i && !empty_o && !flush_i;
  assign head_o    = mem_q[rd_ptr_q];
  assign count_o   = cnt_q;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok_o) wr_ptr_d = wr_ptr_q + 1'b1;
      if (pop_ok_o)  rd_ptr_d = rd_ptr_q + 1'b1;
      case ({push_ok_o, pop_ok_o})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (push_ok_o) mem_q[wr_ptr_q] <= push_data_i;
  end

  // R4: an asserted flush leaves the queue empty
  p_flush_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> cnt_q == '0);

  // R12: an offer to a full queue does not change its level
  p_full_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && full_o && !pop_i && !flush_i |=> cnt_q == $past(cnt_q));

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/afc_irq.sv
module afc_irq
  import afc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] set_i,
  input  logic             clr_we_i,
  input  logic             en_we_i,
  input  logic [STS_W-1:0] wdata_i,
  output logic [STS_W-1:0] sts_o,
  output logic [STS_W-1:0] en_o,
  output logic             irq_o
);
  logic [STS_W-1:0] sts_q, sts_d, en_q, en_d, clr_mask;

  always_comb begin
    clr_mask = clr_we_i ? wdata_i : '0;
    sts_d    = (sts_q & ~clr_mask) | (set_i & ISTS_IMPL);
    en_d     = en_we_i ? (wdata_i & ISTS_IMPL) : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign irq_o = |(sts_q & en_q);

  // R8: a condition present during a clearing write keeps its flag
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    |(set_i & ISTS_IMPL) |=> (sts_q & $past(set_i & ISTS_IMPL)) == $past(set_i & ISTS_IMPL));

  // R8: written ones clear flags whose condition is absent
  p_w1c_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i && (set_i == '0) |=> (sts_q & $past(wdata_i)) == '0);

  // R9: nothing enabled means no interrupt
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_q == '0 |-> !irq_o);
endmodule

// File: rtl/audio_fifo_ctrl.sv
module audio_fifo_ctrl
  import afc_pkg::*;
#(
  parameter int TX_DEPTH   = 128,
  parameter int RX_DEPTH   = 32,
  parameter int DW         = 32,
  parameter int AW         = 6,
  parameter int TRIG_RESET = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_wr_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic          reg_rd_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          tx_req_i,
  output logic          tx_ack_o,
  output logic [DW-1:0] tx_word_o,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_word_i,
  output logic          irq_o
);
  localparam int TX_CW = $clog2(TX_DEPTH + 1);
  localparam int RX_CW = $clog2(RX_DEPTH + 1);

  logic rst_sync_n;

  afc_rst_sync i_rst_sync (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_sync_n));

  // address decode
  logic sel_ctrl, sel_fctl, sel_level, sel_ists, sel_ien;
  logic sel_txdata, sel_rxdata, sel_txcnt, sel_rxcnt;
  assign sel_ctrl   = (reg_addr_i == AW'(OFS_CTRL));
  assign sel_fctl   = (reg_addr_i == AW'(OFS_FCTL));
  assign sel_level  = (reg_addr_i == AW'(OFS_LEVEL));
  assign sel_ists   = (reg_addr_i == AW'(OFS_ISTS));
  assign sel_ien    = (reg_addr_i == AW'(OFS_IEN));
  assign sel_txdata = (reg_addr_i == AW'(OFS_TXDATA));
  assign sel_rxdata = (reg_addr_i == AW'(OFS_RXDATA));
  assign sel_txcnt  = (reg_addr_i == AW'(OFS_TXCNT));
  assign sel_rxcnt  = (reg_addr_i == AW'(OFS_RXCNT));

  // control state
  logic              tx_en_q, tx_en_d, rx_en_q, rx_en_d;
  logic              txfl_q, txfl_d, rxfl_q, rxfl_d;
  logic [TRIG_W-1:0] trig_q, trig_d;
  logic [31:0]       tx_samp_q, tx_samp_d, rx_samp_q, rx_samp_d;

  // queues
  logic [DW-1:0]    tx_head, rx_head;
  logic [TX_CW-1:0] tx_cnt, tx_free;
  logic [RX_CW-1:0] rx_cnt;
  logic             tx_full, tx_empty, tx_push_ok, tx_pop_ok;
  logic             rx_full, rx_empty, rx_push_ok, rx_pop_ok;

  afc_fifo #(.DEPTH(TX_DEPTH), .DW(DW)) i_tx_fifo (
    .clk(clk), .rst_n(rst_sync_n), .flush_i(txfl_q),
    .push_i(reg_wr_i && sel_txdata), .push_data_i(reg_wdata_i[DW-1:0]),
    .pop_i(tx_req_i && tx_en_q), .head_o(tx_head), .count_o(tx_cnt),
    .full_o(tx_full), .empty_o(tx_empty), .push_ok_o(tx_push_ok), .pop_ok_o(tx_pop_ok)
  );

  afc_fifo #(.DEPTH(RX_DEPTH), .DW(DW)) i_rx_fifo (
    .clk(clk), .rst_n(rst_sync_n), .flush_i(rxfl_q),
    .push_i(rx_valid_i && rx_en_q), .push_data_i(rx_word_i),
    .pop_i(reg_rd_i && sel_rxdata), .head_o(rx_head), .count_o(rx_cnt),
    .full_o(rx_full), .empty_o(rx_empty), .push_ok_o(rx_push_ok), .pop_ok_o(rx_pop_ok)
  );

  assign tx_free   = TX_CW'(TX_DEPTH) - tx_cnt;
  assign tx_ack_o  = tx_pop_ok;
  assign tx_word_o = tx_pop_ok ? tx_head : '0;

  // interrupt flags
  logic [STS_W-1:0] ists, ien, sts_set;

  always_comb begin
    sts_set                = '0;
    sts_set[ISTS_UNDERRUN] = tx_req_i && tx_en_q && !tx_pop_ok;
    sts_set[ISTS_TXSPACE]  = 32'(tx_free) >= 32'(trig_q);
    sts_set[ISTS_RXAVAIL]  = !rx_empty;
  end

  afc_irq i_irq (
    .clk(clk), .rst_n(rst_sync_n), .set_i(sts_set),
    .clr_we_i(reg_wr_i && sel_ists), .en_we_i(reg_wr_i && sel_ien),
    .wdata_i(reg_wdata_i[STS_W-1:0]), .sts_o(ists), .en_o(ien), .irq_o(irq_o)
  );

  // next state
  always_comb begin
    tx_en_d   = tx_en_q;
    rx_en_d   = rx_en_q;
    txfl_d    = txfl_q;
    rxfl_d    = rxfl_q;
    trig_d    = trig_q;
    tx_samp_d = tx_samp_q + (tx_pop_ok ? 32'd1 : 32'd0);
    rx_samp_d = rx_samp_q + (rx_push_ok ? 32'd1 : 32'd0);
    if (reg_wr_i && sel_ctrl) begin
      tx_en_d = reg_wdata_i[CTRL_TXEN];
      rx_en_d = reg_wdata_i[CTRL_RXEN];
    end
    if (reg_wr_i && sel_fctl) begin
      txfl_d = reg_wdata_i[FCTL_TXFLUSH];
      rxfl_d = reg_wdata_i[FCTL_RXFLUSH];
      trig_d = reg_wdata_i[TRIG_LSB +: TRIG_W];
    end
    if (reg_wr_i && sel_txcnt) tx_samp_d = reg_wdata_i;
    if (reg_wr_i && sel_rxcnt) rx_samp_d = reg_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tx_en_q   <= 1'b0;
      rx_en_q   <= 1'b0;
      txfl_q    <= 1'b0;
      rxfl_q    <= 1'b0;
      trig_q    <= TRIG_W'(TRIG_RESET);
      tx_samp_q <= '0;
      rx_samp_q <= '0;
    end else begin
      tx_en_q   <= tx_en_d;
      rx_en_q   <= rx_en_d;
      txfl_q    <= txfl_d;
      rxfl_q    <= rxfl_d;
      trig_q    <= trig_d;
      tx_samp_q <= tx_samp_d;
      rx_samp_q <= rx_samp_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    unique case (1'b1)
      sel_ctrl: begin
        reg_rdata_o[CTRL_TXEN] = tx_en_q;
        reg_rdata_o[CTRL_RXEN] = rx_en_q;
      end
      sel_fctl: begin
        reg_rdata_o[FCTL_TXFLUSH]          = txfl_q;
        reg_rdata_o[FCTL_RXFLUSH]          = rxfl_q;
        reg_rdata_o[TRIG_LSB +: TRIG_W]    = trig_q;
      end
      sel_level: begin
        reg_rdata_o[FREE_LSB +: FREE_W] = FREE_W'(tx_free);
        reg_rdata_o[0 +: AVAIL_W]       = AVAIL_W'(rx_cnt);
      end
      sel_ists:   reg_rdata_o = REG_W'(ists);
      sel_ien:    reg_rdata_o = REG_W'(ien);
      sel_rxdata: reg_rdata_o = rx_empty ? '0 : REG_W'(rx_head);
      sel_txcnt:  reg_rdata_o = tx_samp_q;
      sel_rxcnt:  reg_rdata_o = rx_samp_q;
      default:    reg_rdata_o = '0;
    endcase
  end

  // R6: an unserved request while enabled raises the underrun flag
  p_underrun_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_en_q && tx_req_i && tx_empty |=> ists[ISTS_UNDERRUN]);

  // R5: free space at or above the trigger raises the space flag
  p_space_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    32'(tx_free) >= 32'(trig_q) |=> ists[ISTS_TXSPACE]);

  // R7: stored receive data raises the available flag
  p_rxavail_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rx_empty |=> ists[ISTS_RXAVAIL]);

  // R11: a disabled transmit path delivers nothing
  p_tx_idle_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tx_en_q |-> !tx_ack_o);

  // R10: each delivered word advances the transmit counter by one
  p_txcnt_step_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_ack_o && !(reg_wr_i && sel_txcnt) |=> tx_samp_q == $past(tx_samp_q) + 32'd1);

  // R12: a full receive queue does not advance the receive counter
  p_rxcnt_full_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_full && !(reg_wr_i && (sel_rxcnt || sel_rxdata)) |=> rx_samp_q == $past(rx_samp_q));
endmodule

// File: tb/test_audio_fifo_ctrl.sv
module test_audio_fifo_ctrl;
  logic        clk;
  logic        rst_n;
  logic [5:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic        reg_rd;
  logic [31:0] reg_rdata;
  logic        tx_req;
  logic        tx_ack;
  logic [31:0] tx_word;
  logic        rx_valid;
  logic [31:0] rx_word;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  audio_fifo_ctrl i_audio_fifo_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rd_i(reg_rd), .reg_rdata_o(reg_rdata),
    .tx_req_i(tx_req), .tx_ack_o(tx_ack), .tx_word_o(tx_word),
    .rx_valid_i(rx_valid), .rx_word_i(rx_word), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  localparam logic [5:0] A_CTRL = 6'h00, A_FCTL = 6'h04, A_LEVEL = 6'h08,
    A_ISTS = 6'h0C, A_IEN = 6'h10, A_TXD = 6'h14, A_RXD = 6'h18,
    A_TXC = 6'h1C, A_RXC = 6'h20;

  // {trigger[6:0], words written[7:0], expected free[7:0], expected space flag}
  localparam int NVEC = 8;
  localparam logic [23:0] VEC [NVEC] = '{
    {7'd64,  8'd64,  8'd64,  1'b1},
    {7'd64,  8'd65,  8'd63,  1'b0},
    {7'd0,   8'd128, 8'd0,   1'b1},
    {7'd127, 8'd0,   8'd128, 1'b1},
    {7'd127, 8'd1,   8'd127, 1'b1},
    {7'd127, 8'd2,   8'd126, 1'b0},
    {7'd1,   8'd128, 8'd0,   1'b0},
    {7'd0,   8'd130, 8'd0,   1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pull(output logic ack, output logic [31:0] w);
    @(negedge clk);
    tx_req = 1'b1;
    #1 ack = tx_ack; w = tx_word;
    @(negedge clk);
    tx_req = 1'b0;
  endtask

  task automatic offer(input logic [31:0] w);
    @(negedge clk);
    rx_valid = 1'b1; rx_word = w;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        ack;
    reg_addr = '0; reg_wr = 0; reg_wdata = '0; reg_rd = 0;
    tx_req = 0; rx_valid = 0; rx_word = '0;
    rst_n = 0;
    idle(4);
    rst_n = 1;
    idle(5);

    // R1 reset state
    rd(A_LEVEL, d); chk("R1 level", d, 32'h0080_0000);
    rd(A_FCTL, d);  chk("R1 fifo control", d, 32'h0004_0000);
    rd(A_CTRL, d);  chk("R1 control", d, 32'h0);
    rd(A_IEN, d);   chk("R1 enable", d, 32'h0);
    rd(A_TXC, d);   chk("R1 tx counter", d, 32'h0);
    rd(A_RXC, d);   chk("R1 rx counter", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rd(A_ISTS, d);  chk("R5 space after reset", d, 32'h10);

    // R5 table: trigger versus free space; R2 free field; R12 tx full
    for (int i = 0; i < NVEC; i++) begin
      logic [6:0] trig;
      logic [7:0] nw, efree;
      logic       esp;
      {trig, nw, efree, esp} = VEC[i];
      wr(A_FCTL, (32'h1 << 25) | (32'(trig) << 12));
      wr(A_FCTL, 32'(trig) << 12);
      for (int k = 0; k < int'(nw); k++) wr(A_TXD, 32'h5000_0000 + 32'(k));
      idle(2);
      rd(A_LEVEL, d); chk("R2 R12 free count", 32'(d[23:16]), 32'(efree));
      wr(A_ISTS, 32'h10);
      idle(2);
      rd(A_ISTS, d);  chk("R5 space flag", 32'(d[4]), 32'(esp));
    end
    wr(A_FCTL, (32'h1 << 25) | (32'd64 << 12));
    wr(A_FCTL, 32'd64 << 12);

    // R2 ordering and delivery
    wr(A_CTRL, 32'h4);
    wr(A_TXD, 32'hA1A1_0001);
    wr(A_TXD, 32'hB2B2_0002);
    wr(A_TXD, 32'hC3C3_0003);
    pull(ack, d); chk("R2 ack 1", 32'(ack), 32'h1); chk("R2 word 1", d, 32'hA1A1_0001);
    pull(ack, d); chk("R2 word 2", d, 32'hB2B2_0002);
    pull(ack, d); chk("R2 word 3", d, 32'hC3C3_0003);
    rd(A_LEVEL, d); chk("R2 free restored", d, 32'h0080_0000);
    rd(A_TXC, d);   chk("R10 tx counter", d, 32'd3);
    wr(A_TXC, 32'h0);
    rd(A_TXC, d);   chk("R10 tx counter cleared", d, 32'h0);

    // R6 underrun, R8 write-zero and write-one
    wr(A_ISTS, 32'h40);
    pull(ack, d); chk("R6 no ack on empty", 32'(ack), 32'h0);
    idle(1);
    rd(A_ISTS, d); chk("R6 underrun set", 32'(d[6]), 32'h1);
    wr(A_ISTS, 32'h0);
    rd(A_ISTS, d); chk("R8 zero write keeps", 32'(d[6]), 32'h1);
    wr(A_ISTS, 32'h40);
    idle(1);
    rd(A_ISTS, d); chk("R8 one write clears", 32'(d[6]), 32'h0);
    rd(A_TXC, d);  chk("R10 no count on underrun", d, 32'h0);

    // R11 transmit disabled
    wr(A_CTRL, 32'h0);
    wr(A_TXD, 32'h7777_0007);
    pull(ack, d); chk("R11 tx off no ack", 32'(ack), 32'h0);
    rd(A_LEVEL, d); chk("R11 tx off free kept", 32'(d[23:16]), 32'd127);
    rd(A_ISTS, d);  chk("R11 tx off no underrun", 32'(d[6]), 32'h0);
    wr(A_FCTL, (32'h1 << 25) | (32'd64 << 12));
    wr(A_FCTL, 32'd64 << 12);
    wr(A_ISTS, 32'h40);
    pull(ack, d);
    idle(1);
    rd(A_ISTS, d);  chk("R11 empty tx off no underrun", 32'(d[6]), 32'h0);
    offer(32'hDEAD_0001);
    rd(A_LEVEL, d); chk("R11 rx off ignored", 32'(d[5:0]), 32'h0);

    // R3 receive path, R7 flag, R9 irq
    wr(A_CTRL, 32'h6);
    offer(32'hE0E0_0000);
    offer(32'hE1E1_0001);
    idle(1);
    rd(A_LEVEL, d); chk("R3 avail count", 32'(d[5:0]), 32'd2);
    rd(A_ISTS, d);  chk("R7 avail flag", 32'(d[0]), 32'h1);
    chk("R9 irq masked", 32'(irq), 32'h0);
    wr(A_IEN, 32'h01);
    idle(1);
    chk("R9 irq enabled", 32'(irq), 32'h1);
    rd(A_RXD, d); chk("R3 first word", d, 32'hE0E0_0000);
    rd(A_RXD, d); chk("R3 second word", d, 32'hE1E1_0001);
    rd(A_RXD, d); chk("R3 empty read", d, 32'h0);
    wr(A_ISTS, 32'h01);
    idle(1);
    rd(A_ISTS, d);  chk("R7 flag cleared", 32'(d[0]), 32'h0);
    chk("R9 irq drops", 32'(irq), 32'h0);
    rd(A_RXC, d);   chk("R10 rx counter", d, 32'd2);
    wr(A_IEN, 32'h10);
    idle(1);
    chk("R9 space irq", 32'(irq), 32'h1);
    wr(A_IEN, 32'h0);
    idle(1);
    chk("R9 all masked", 32'(irq), 32'h0);

    // R11 independence: rx off, tx on
    wr(A_CTRL, 32'h4);
    wr(A_TXD, 32'h1234_5678);
    offer(32'hBAD0_0000);
    pull(ack, d); chk("R11 tx still runs", d, 32'h1234_5678);
    rd(A_LEVEL, d); chk("R11 rx still off", 32'(d[5:0]), 32'h0);

    // R12 receive full, R4 receive flush
    wr(A_CTRL, 32'h2);
    wr(A_RXC, 32'h0);
    for (int k = 0; k < 34; k++) offer(32'hF000_0000 + 32'(k));
    rd(A_LEVEL, d); chk("R12 rx full level", 32'(d[5:0]), 32'd32);
    rd(A_RXC, d);   chk("R12 rx counter capped", d, 32'd32);
    rd(A_RXD, d);   chk("R12 oldest kept", d, 32'hF000_0000);
    wr(A_FCTL, (32'h1 << 24) | (32'd64 << 12));
    offer(32'hF0F0_F0F0);
    wr(A_FCTL, 32'd64 << 12);
    rd(A_LEVEL, d); chk("R4 rx flushed", 32'(d[5:0]), 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule